// File: doc/BRIEF.md
# Relocatable SRAM Array Controller

This block is a 1 KB on-chip static RAM. It answers on a 24-bit bus at a base address that software can move. A small register port holds the placement: a high and a low base register, and a control register. The control register has a halt bit, a lock bit that can be set only once, and a two-bit field that picks which bus spaces the array answers to. The base registers accept writes only while the block is halted and not locked. Once the lock bit is set, the map stays frozen until reset.

A bus master raises `req_i` with the address, size, direction and space code, and holds them steady. Each bus cycle lasts two clocks and ends with a one-clock `ack_o` pulse. A byte access or an even-address word access takes one bus cycle. A long word or an odd-address word takes two bus cycles. The master drops `req_i` on the clock of the final acknowledge.

The array stays silent in these cases:
- the block is halted;
- the standby-supply input is active;
- the space filter rejects the access;
- the base lies in a region that sign-extended addresses can never reach.

The register port stays usable at all times, and the array contents survive reset.

Top module: `sram_reloc_ctrl`

## Requirements
- R1: After reset the control register reads 16'h8000 (halt bit 15 = 1, lock bit 14 = 0, space field bits 1:0 = 00). Both base registers read 0. The array contents are not cleared by reset.
- R2: A write to the base-high register (select 1, bits 7:0 = address bits 23:16) or the base-low register (select 2, bits 15:10 = address bits 15:10) takes effect only when halt = 1 and lock = 0. Otherwise the write is ignored.
- R3: Writing 1 to lock bit 14 of the control register (select 0) sets it. No later write clears it. Only reset clears it.
- R4: An access is acknowledged only when address bits 23:10 equal the base. Base-low bits 9:0 are ignored and read as 0. An address just outside the 1 KB window gets no acknowledge.
- R5: When space bit 0 is 1, only accesses with `fc_i` = 1 (program space) are served. When space bit 0 is 0, both program and data accesses are served. Space bit 1 has no effect.
- R6: A base in $080000 to $7FFFFF (bit 23 = 0 and bits 22:19 not all 0) never matches any access. The same array contents appear again once the base is moved out of that range.
- R7: A byte access (`size_i` = 00) or an even-address word access (`size_i` = 01) gives exactly one acknowledge, in the second clock after the access is accepted.
- R8: A long-word access (`size_i` = 1x) or an odd-address word access gives two acknowledges, two clocks apart, with one clock of `ack_o` low between them.
- R9: While `standby_i` is 1, no access is acknowledged and no write reaches the array. The contents are intact afterwards.
- R10: While halt = 1, no access is acknowledged, but the registers remain readable and writable.
- R11: Data are big-endian and right-justified. A byte uses bits 7:0, a word uses 15:0 with the even address in 15:8, and a long uses 31:0 with the lowest address in 31:24. A write changes only the bytes it addresses, and the offset wraps inside the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| standby_i | input | 1 | Array is running from the standby supply |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 control, 1 base high, 2 base low |
| cfg_wdata_i | input | 16 | Register write data |
| cfg_rdata_o | output | 16 | Register read data for the selected register |
| req_i | input | 1 | Bus access request, held until the final acknowledge |
| rw_i | input | 1 | 1 = read, 0 = write |
| size_i | input | 2 | 00 byte, 01 word, 1x long word |
| addr_i | input | 24 | Byte address |
| fc_i | input | 1 | 1 = program space, 0 = data space |
| wdata_i | input | 32 | Write data, right-justified |
| rdata_o | output | 32 | Read data, valid while `ack_o` is 1 |
| ack_o | output | 1 | End of one bus cycle |

## Verification
The request is accepted at the first rising edge after `req_i` rises. The first acknowledge is due two edges later, and the second one for a two-bus-cycle access is due two edges after that. The bench therefore counts negative edges from the moment it drives the request, expects `ack_o` at counts 2 and 4 only, and samples read data at the final acknowledge. Register writes take effect at the edge between the strobe's negative edges, so the bench reads them back at the following negative edge. For a blocked access the bench holds the request for eight clocks and requires that no acknowledge appears.

// File: rtl/sram_reloc_pkg.sv
// Package: shared encodings for the relocatable SRAM controller.
// Assumes a 2-bit size code where bit 1 set means a long word.
package sram_reloc_pkg;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_WORD = 2'b01;

    localparam logic [1:0] SEL_CTRL    = 2'd0;
    localparam logic [1:0] SEL_BASE_HI = 2'd1;
    localparam logic [1:0] SEL_BASE_LO = 2'd2;

    localparam int CTRL_HALT_BIT = 15;
    localparam int CTRL_LOCK_BIT = 14;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_HOLD = 2'd3
    } seq_state_t;

    // True when the access needs two bus cycles (long word, or odd-address word).
    function automatic logic needs_two(input logic [1:0] sz, input logic a0);
        return sz[1] | ((sz == SZ_WORD) & a0);
    endfunction

endpackage

// File: rtl/sram_cfg_regs.sv
// Module: control and base registers.
// Holds halt, the write-once lock, the space field and the 1 KB-aligned base.
// Assumes ADDR_W > REG_W > OFS_W. The base-high register carries address bits above REG_W.
module sram_cfg_regs
    import sram_reloc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int REG_W  = 16,
    parameter int OFS_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we_i,
    input  logic [1:0]              cfg_sel_i,
    input  logic [REG_W-1:0]        cfg_wdata_i,
    output logic [REG_W-1:0]        cfg_rdata_o,
    output logic                    halt_o,
    output logic                    lock_o,
    output logic [1:0]              space_o,
    output logic [ADDR_W-1:OFS_W]   base_o
);
    localparam int HI_W = ADDR_W - REG_W;

    logic                  halt_q;
    logic                  lock_q;
    logic [1:0]            space_q;
    logic [ADDR_W-1:OFS_W] base_q;
    logic                  base_wr_ok;
    logic                  unused_wbits;

    assign base_wr_ok   = halt_q & ~lock_q;
    assign unused_wbits = ^cfg_wdata_i;

    // Purpose: update the control register and, when permitted, the base registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q  <= 1'b1;
            lock_q  <= 1'b0;
            space_q <= 2'b00;
            base_q  <= '0;
        end else if (cfg_we_i) begin
            case (cfg_sel_i)
                SEL_CTRL: begin
                    halt_q  <= cfg_wdata_i[CTRL_HALT_BIT];
                    lock_q  <= lock_q | cfg_wdata_i[CTRL_LOCK_BIT];
                    space_q <= cfg_wdata_i[1:0];
                end
                SEL_BASE_HI: if (base_wr_ok) base_q[ADDR_W-1:REG_W] <= cfg_wdata_i[HI_W-1:0];
                SEL_BASE_LO: if (base_wr_ok) base_q[REG_W-1:OFS_W]  <= cfg_wdata_i[REG_W-1:OFS_W];
                default: ;
            endcase
        end
    end

    // Purpose: return the selected register; base bits below the alignment read 0.
    always_comb begin
        cfg_rdata_o = '0;
        case (cfg_sel_i)
            SEL_CTRL: begin
                cfg_rdata_o[CTRL_HALT_BIT] = halt_q;
                cfg_rdata_o[CTRL_LOCK_BIT] = lock_q;
                cfg_rdata_o[1:0]           = space_q;
            end
            SEL_BASE_HI: cfg_rdata_o = {{(REG_W-HI_W){1'b0}}, base_q[ADDR_W-1:REG_W]};
            SEL_BASE_LO: cfg_rdata_o = {base_q[REG_W-1:OFS_W], {OFS_W{1'b0}}};
            default:     cfg_rdata_o = '0;
        endcase
    end

    assign halt_o  = halt_q;
    assign lock_o  = lock_q;
    assign space_o = space_q;
    assign base_o  = base_q;

    // R3: once set, the lock holds until reset.
    assert_lock_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    // R2: the base cannot move while running or locked.
    assert_base_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_q || lock_q) |=> $stable(base_q));

endmodule

// File: rtl/sram_addr_decode.sv
// Module: address and space decode.
// Flags a request that the array may serve. Assumes the upper address bits
// are copies of bit SEXT_BIT, so a base whose top bit is 0 but whose bits
// between the top bit and SEXT_BIT are not all 0 can never be reached.
module sram_addr_decode #(
    parameter int ADDR_W   = 24,
    parameter int OFS_W    = 10,
    parameter int SEXT_BIT = 19
) (
    input  logic                  req_i,
    input  logic [ADDR_W-1:OFS_W] addr_hi_i,
    input  logic                  fc_i,
    input  logic                  halt_i,
    input  logic                  standby_i,
    input  logic [1:0]            space_i,
    input  logic [ADDR_W-1:OFS_W] base_i,
    output logic                  hit_o
);
    logic base_reachable;
    logic space_ok;
    logic addr_match;
    logic unused_space;

    assign unused_space = space_i[1];

    // Purpose: combine placement, space filter and module state into one hit flag.
    always_comb begin
        base_reachable = base_i[ADDR_W-1] | (base_i[ADDR_W-2:SEXT_BIT] == '0);
        space_ok       = ~space_i[0] | fc_i;
        addr_match     = (addr_hi_i == base_i);
        hit_o          = req_i & ~halt_i & ~standby_i & base_reachable & space_ok & addr_match;
    end

endmodule

// File: rtl/sram_seq.sv
// Module: bus-cycle sequencer.
// Accepts a hit, latches the access and runs one or two bus cycles of two
// clocks each (address clock, then acknowledge clock). Assumes the master
// holds req until the final acknowledge. A standby condition abandons the access.
module sram_seq
    import sram_reloc_pkg::*;
#(
    parameter int OFS_W  = 10,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              hit_i,
    input  logic              standby_i,
    input  logic              rw_i,
    input  logic [1:0]        size_i,
    input  logic [OFS_W-1:0]  ofs_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              ack_o,
    output logic              commit_o,
    output logic [1:0]        size_o,
    output logic [OFS_W-1:0]  ofs_o,
    output logic [DATA_W-1:0] wdata_o
);
    seq_state_t        state_q;
    logic              idx_q;
    logic              two_q;
    logic              rw_q;
    logic [1:0]        size_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [DATA_W-1:0] wdata_q;
    logic              last_cycle;

    assign ack_o      = (state_q == ST_DATA);
    assign last_cycle = ack_o & (idx_q == two_q);
    assign commit_o   = last_cycle & ~standby_i & ~rw_q;

    // Purpose: step through address and acknowledge clocks for each bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= 1'b0;
            two_q   <= 1'b0;
            rw_q    <= 1'b1;
            size_q  <= SZ_BYTE;
            ofs_q   <= '0;
            wdata_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (hit_i) begin
                    state_q <= ST_ADDR;
                    idx_q   <= 1'b0;
                    two_q   <= needs_two(size_i, ofs_i[0]);
                    rw_q    <= rw_i;
                    size_q  <= size_i;
                    ofs_q   <= ofs_i;
                    wdata_q <= wdata_i;
                end
                ST_ADDR: state_q <= standby_i ? ST_IDLE : ST_DATA;
                ST_DATA: begin
                    if (standby_i)       state_q <= ST_IDLE;
                    else if (last_cycle) state_q <= req_i ? ST_HOLD : ST_IDLE;
                    else begin
                        idx_q   <= 1'b1;
                        state_q <= ST_ADDR;
                    end
                end
                ST_HOLD: if (!req_i) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign size_o  = size_q;
    assign ofs_o   = ofs_q;
    assign wdata_o = wdata_q;

    // R8: two acknowledges are never adjacent.
    assert_ack_spaced_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    // R9: standby silences the next clock's acknowledge.
    assert_standby_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> !ack_o);

endmodule

// File: rtl/sram_store.sv
// Module: byte-organised storage array with big-endian lane steering.
// Lane g handles the byte at offset+g; offsets wrap inside the array.
// Data on the bus side are right-justified. Contents have no reset.
module sram_store
    import sram_reloc_pkg::*;
#(
    parameter int ARRAY_BYTES = 1024,
    parameter int DATA_W      = 32
) (
    input  logic                           clk,
    input  logic                           we_i,
    input  logic [$clog2(ARRAY_BYTES)-1:0] ofs_i,
    input  logic [1:0]                     size_i,
    input  logic [DATA_W-1:0]              wdata_i,
    output logic [DATA_W-1:0]              rdata_o
);
    localparam int OFS_W = $clog2(ARRAY_BYTES);
    localparam int LANES = DATA_W / 8;
    localparam int SH_W  = $clog2(DATA_W) + 1;

    logic [7:0]        mem [ARRAY_BYTES];
    logic [OFS_W-1:0]  lane_addr [LANES];
    logic [LANES-1:0]  lane_en;
    logic [SH_W-1:0]   pad_bits;
    logic [DATA_W-1:0] wleft;
    logic [DATA_W-1:0] rleft;

    // Purpose: number of unused high bits for the access size.
    always_comb begin
        case (size_i)
            SZ_BYTE: pad_bits = SH_W'(DATA_W - 8);
            SZ_WORD: pad_bits = SH_W'(DATA_W - 16);
            default: pad_bits = '0;
        endcase
        wleft   = wdata_i << pad_bits;
        rdata_o = rleft >> pad_bits;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_addr[g] = ofs_i + OFS_W'(g);
        assign lane_en[g]   = (size_i == SZ_BYTE) ? (g == 0) :
                              (size_i == SZ_WORD) ? (g < 2)  : 1'b1;
        assign rleft[DATA_W-1-8*g -: 8] = mem[lane_addr[g]];
    end

    // Purpose: write the enabled byte lanes of a committed access.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (we_i && lane_en[i]) mem[lane_addr[i]] <= wleft[DATA_W-1-8*i -: 8];
        end
    end

endmodule

// File: rtl/sram_reloc_ctrl.sv
// Module: relocatable SRAM controller top.
// Wires the register block, decode, sequencer and storage. Read data are
// driven only while an acknowledge is shown. Assumes one master that holds
// its request fields stable until the final acknowledge.
module sram_reloc_ctrl #(
    parameter int ADDR_W      = 24,
    parameter int DATA_W      = 32,
    parameter int REG_W       = 16,
    parameter int ARRAY_BYTES = 1024,
    parameter int SEXT_BIT    = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_i,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [REG_W-1:0]  cfg_wdata_i,
    output logic [REG_W-1:0]  cfg_rdata_o,
    input  logic              req_i,
    input  logic              rw_i,
    input  logic [1:0]        size_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              fc_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ack_o
);
    localparam int OFS_W     = $clog2(ARRAY_BYTES);
    localparam int DRAIN_CLK = 5;

    logic                  halt;
    logic                  lock;
    logic [1:0]            space;
    logic [ADDR_W-1:OFS_W] base;
    logic                  hit;
    logic                  commit;
    logic [1:0]            acc_size;
    logic [OFS_W-1:0]      acc_ofs;
    logic [DATA_W-1:0]     acc_wdata;
    logic [DATA_W-1:0]     store_rdata;
    logic                  unused_lock;

    assign unused_lock = lock;

    sram_cfg_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W), .OFS_W(OFS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
        .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
        .halt_o(halt), .lock_o(lock), .space_o(space), .base_o(base)
    );

    sram_addr_decode #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .SEXT_BIT(SEXT_BIT)) u_dec (
        .req_i(req_i), .addr_hi_i(addr_i[ADDR_W-1:OFS_W]), .fc_i(fc_i),
        .halt_i(halt), .standby_i(standby_i), .space_i(space), .base_i(base),
        .hit_o(hit)
    );

    sram_seq #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .hit_i(hit), .standby_i(standby_i),
        .rw_i(rw_i), .size_i(size_i), .ofs_i(addr_i[OFS_W-1:0]), .wdata_i(wdata_i),
        .ack_o(ack_o), .commit_o(commit), .size_o(acc_size), .ofs_o(acc_ofs),
        .wdata_o(acc_wdata)
    );

    sram_store #(.ARRAY_BYTES(ARRAY_BYTES), .DATA_W(DATA_W)) u_store (
        .clk(clk), .we_i(commit), .ofs_i(acc_ofs), .size_i(acc_size),
        .wdata_i(acc_wdata), .rdata_o(store_rdata)
    );

    assign rdata_o = ack_o ? store_rdata : '0;

    // Purpose: count consecutive halted clocks, for the halt assertion below.
    logic [2:0] halt_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                       halt_run_q <= '0;
        else if (!halt)                   halt_run_q <= '0;
        else if (halt_run_q != DRAIN_CLK) halt_run_q <= halt_run_q + 3'd1;
    end

    // R10: after any in-flight access has drained, a halted array stays silent.
    assert_halt_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_run_q == DRAIN_CLK) |-> !ack_o);

endmodule

// File: tb/tb_sram_reloc_ctrl.sv
`timescale 1ns/1ps
module tb_sram_reloc_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby_i = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [1:0]  cfg_sel_i = '0;
    logic [15:0] cfg_wdata_i = '0;
    logic [15:0] cfg_rdata_o;
    logic        req_i = 1'b0;
    logic        rw_i = 1'b1;
    logic [1:0]  size_i = '0;
    logic [23:0] addr_i = '0;
    logic        fc_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        ack_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    sram_reloc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .standby_i(standby_i), .cfg_we_i(cfg_we_i),
        .cfg_sel_i(cfg_sel_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
        .req_i(req_i), .rw_i(rw_i), .size_i(size_i), .addr_i(addr_i), .fc_i(fc_i),
        .wdata_i(wdata_i), .rdata_o(rdata_o), .ack_o(ack_o)
    );

    // Vector layout: {rw, size, fc, addr, wdata, acks, expected rdata}; rw 1 = read.
    localparam int NVEC = 17;
    localparam logic [93:0] VEC [NVEC] = '{
        {1'b0, 2'b10, 1'b0, 24'hFF0400, 32'h11223344, 2'd2, 32'h0},        // R8 long write
        {1'b1, 2'b00, 1'b0, 24'hFF0400, 32'h0,        2'd1, 32'h00000011}, // R7 R11
        {1'b1, 2'b00, 1'b1, 24'hFF0403, 32'h0,        2'd1, 32'h00000044}, // R7 R11
        {1'b1, 2'b01, 1'b0, 24'hFF0402, 32'h0,        2'd1, 32'h00003344}, // R7 aligned word
        {1'b1, 2'b01, 1'b0, 24'hFF0401, 32'h0,        2'd2, 32'h00002233}, // R8 odd word
        {1'b0, 2'b01, 1'b0, 24'hFF0404, 32'h00005566, 2'd1, 32'h0},
        {1'b0, 2'b00, 1'b0, 24'hFF0405, 32'h000000AB, 2'd1, 32'h0},        // R11 single byte
        {1'b0, 2'b01, 1'b0, 24'hFF0407, 32'h0000CDEF, 2'd2, 32'h0},        // R8 odd word write
        {1'b0, 2'b00, 1'b0, 24'hFF0406, 32'h00000077, 2'd1, 32'h0},
        {1'b1, 2'b10, 1'b0, 24'hFF0404, 32'h0,        2'd2, 32'h55AB77CD}, // R11 merge
        {1'b1, 2'b00, 1'b0, 24'hFF0408, 32'h0,        2'd1, 32'h000000EF},
        {1'b0, 2'b10, 1'b0, 24'hFF07FC, 32'hA1B2C3D4, 2'd2, 32'h0},        // top of window
        {1'b1, 2'b01, 1'b0, 24'hFF07FE, 32'h0,        2'd1, 32'h0000C3D4},
        {1'b1, 2'b00, 1'b0, 24'hFF0800, 32'h0,        2'd0, 32'h0},        // R4 above window
        {1'b1, 2'b00, 1'b0, 24'hFF03FF, 32'h0,        2'd0, 32'h0},        // R4 below window
        {1'b0, 2'b10, 1'b1, 24'hFE0400, 32'hDEADBEEF, 2'd0, 32'h0},        // R4 miss
        {1'b1, 2'b11, 1'b0, 24'hFF0400, 32'h0,        2'd2, 32'h11223344}  // R8 size 11 as long
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic cfg_check(input string tag, input logic [1:0] sel, input logic [15:0] exp);
        cfg_sel_i = sel;
        #0.1;
        chk(tag, {16'h0, cfg_rdata_o}, {16'h0, exp});
    endtask

    // Drives one access; counts acks over 8 clocks and checks their timing and data.
    task automatic do_acc(input string tag, input logic rw, input logic [1:0] sz,
                          input logic fc, input logic [23:0] a, input logic [31:0] wd,
                          input int nexp, input logic [31:0] exp);
        int nack = 0;
        int c1 = -1;
        int c2 = -1;
        logic [31:0] rd = '0;
        @(negedge clk);
        req_i = 1'b1; rw_i = rw; size_i = sz; fc_i = fc; addr_i = a; wdata_i = wd;
        for (int cyc = 1; cyc <= 8; cyc++) begin
            @(negedge clk);
            if (ack_o) begin
                nack++;
                if (nack == 1) c1 = cyc; else c2 = cyc;
                rd = rdata_o;
                if (nack >= nexp) req_i = 1'b0;
            end
        end
        req_i = 1'b0;
        chk({tag, " ack count"}, nack, nexp);
        if (nexp >= 1) chk({tag, " first ack clock"}, c1, 2);
        if (nexp == 2) chk({tag, " second ack clock"}, c2, 4);
        if (rw && nexp > 0) chk({tag, " read data R11"}, rd, exp);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        cfg_check("R1 ctrl", 2'd0, 16'h8000);
        cfg_check("R1 base hi", 2'd1, 16'h0000);
        cfg_check("R1 base lo", 2'd2, 16'h0000);
        do_acc("R1 halted after reset", 1'b1, 2'b00, 1'b0, 24'h000000, 32'h0, 0, 32'h0);

        // R2 / R4 base programming
        cfg_write(2'd1, 16'h00FF);
        cfg_check("R2 base hi written while halted", 2'd1, 16'h00FF);
        cfg_write(2'd2, 16'h07FF);
        cfg_check("R4 base lo low bits ignored", 2'd2, 16'h0400);
        cfg_write(2'd0, 16'h0000);
        cfg_check("R10 ctrl cleared halt", 2'd0, 16'h0000);
        cfg_write(2'd1, 16'h0012);
        cfg_check("R2 base hi ignored while running", 2'd1, 16'h00FF);

        // Main vector walk (R4 R7 R8 R11)
        for (int i = 0; i < NVEC; i++) begin
            logic [93:0] v;
            string tag;
            v = VEC[i];
            tag = (v[33:32] == 2'd2) ? "R8" : (v[33:32] == 2'd1) ? "R7" : "R4";
            do_acc($sformatf("%s vec%0d", tag, i), v[93], v[92:91], v[90], v[89:66],
                   v[65:34], int'(v[33:32]), v[31:0]);
        end

        // R5 space filter
        cfg_write(2'd0, 16'h0001);
        do_acc("R5 data rejected", 1'b1, 2'b00, 1'b0, 24'hFF0400, 32'h0, 0, 32'h0);
        do_acc("R5 program served", 1'b1, 2'b00, 1'b1, 24'hFF0400, 32'h0, 1, 32'h11);
        cfg_write(2'd0, 16'h0002);
        do_acc("R5 bit1 no effect", 1'b1, 2'b00, 1'b0, 24'hFF0400, 32'h0, 1, 32'h11);

        // R10 halt blocks the array, registers still work
        cfg_write(2'd0, 16'h8000);
        do_acc("R10 halted access", 1'b1, 2'b00, 1'b0, 24'hFF0400, 32'h0, 0, 32'h0);
        cfg_write(2'd0, 16'h8003);
        cfg_check("R10 ctrl written while halted", 2'd0, 16'h8003);

        // R6 unreachable bases
        cfg_write(2'd1, 16'h0008);
        cfg_check("R2 base hi to 08", 2'd1, 16'h0008);
        cfg_write(2'd0, 16'h0000);
        do_acc("R6 base 080400", 1'b1, 2'b00, 1'b0, 24'h080400, 32'h0, 0, 32'h0);
        cfg_write(2'd0, 16'h8000);
        cfg_write(2'd1, 16'h007F);
        cfg_write(2'd0, 16'h0000);
        do_acc("R6 base 7F0400", 1'b1, 2'b00, 1'b0, 24'h7F0400, 32'h0, 0, 32'h0);
        cfg_write(2'd0, 16'h8000);
        cfg_write(2'd1, 16'h0000);
        cfg_write(2'd0, 16'h0000);
        do_acc("R6 base 000400 reachable", 1'b1, 2'b00, 1'b0, 24'h000400, 32'h0, 1, 32'h11);

        // R9 standby
        @(negedge clk);
        standby_i = 1'b1;
        do_acc("R9 write in standby", 1'b0, 2'b00, 1'b0, 24'h000400, 32'h99, 0, 32'h0);
        do_acc("R9 read in standby", 1'b1, 2'b00, 1'b0, 24'h000400, 32'h0, 0, 32'h0);
        standby_i = 1'b0;
        do_acc("R9 contents kept", 1'b1, 2'b00, 1'b0, 24'h000400, 32'h0, 1, 32'h11);

        // R3 write-once lock
        cfg_write(2'd0, 16'h8000);
        cfg_write(2'd0, 16'hC000);
        cfg_check("R3 lock set", 2'd0, 16'hC000);
        cfg_write(2'd1, 16'h00FF);
        cfg_check("R2 base hi ignored when locked", 2'd1, 16'h0000);
        cfg_write(2'd0, 16'h8000);
        cfg_check("R3 lock not cleared", 2'd0, 16'hC000);
        cfg_write(2'd0, 16'h0000);
        cfg_check("R3 lock kept with halt clear", 2'd0, 16'h4000);

        // R1 reset clears registers but keeps the array
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_check("R1 ctrl after second reset", 2'd0, 16'h8000);
        cfg_check("R1 base lo after second reset", 2'd2, 16'h0000);
        do_acc("R1 halted after second reset", 1'b1, 2'b00, 1'b0, 24'h000000, 32'h0, 0, 32'h0);
        cfg_write(2'd0, 16'h0000);
        do_acc("R1 array survives reset", 1'b1, 2'b00, 1'b0, 24'h000000, 32'h0, 1, 32'h11);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule